// File: doc/BRIEF.md
# Card Window Decoder

This block maps host addresses onto a removable-card socket through eight programmable windows. Each window has a base register and an option register. A host request is compared against every enabled window. The lowest-numbered matching window supplies the card-side attributes: socket, space type, port width and write protection. It also supplies the strobe timing that shapes the card cycle.

An accepted request runs through up to three timed phases. In the setup phase the address is valid. In the strobe phase the card strobe is asserted. In the hold phase the address stays on the bus with the strobe released. The acknowledge pulse follows the last phase. A request that hits no window, or that writes a protected window, is acknowledged at once with an error flag and produces no card cycle. The address driven toward the card is the low 26 bits of the host address.

Software loads the windows through a one-cycle configuration write port. A written value takes effect for requests sampled on later clock edges.

Top module: `card_window_decoder`

## Requirements
- R1: After reset no window is valid, and `ack`, `strobe` and `addr_valid` are low. A request made then is a miss.
- R2: Option register field layout:
  - bit 0: valid
  - bit 1: write protect
  - bit 2: socket B select, driven on `socket_b`
  - bits 5:3: space code, driven on `space` (0 common, 2 attribute, 3 I/O, 4 DMA, 5 DMA last, 6 upper-address-on-enables)
  - bit 6: 16-bit port, driven on `port16` (0 means 8-bit)
- R3: Option bits 31:27 hold the reflected Gray code of n, where the window size is 2^n bytes. A window hits when its valid bit is set and the host address equals the base on every bit at position n and above.
- R4: A request that hits no window is acknowledged on the first cycle after it is sampled. It has `err`=1 and `hit`=0, and no strobe and no address-valid cycle.
- R5: When several windows hit, `win_idx` reports the lowest-numbered one, and its attributes are used.
- R6: A write to a write-protected window gives no strobe. It is acknowledged on the first cycle with `err`=1 and `hit`=1. A read of the same window runs a normal card cycle with `err`=0.
- R7: A hit gives a card cycle with these timings, all counted in clock cycles, followed by a one-cycle `ack`:
  - setup: option bits 15:12. `addr_valid` is high with `strobe` low before the strobe.
  - strobe length: option bits 11:7. `strobe` is high.
  - hold: option bits 19:16. `addr_valid` stays high after the strobe.
  - A phase whose count is zero is skipped.
- R8: `card_addr` equals the low 26 bits of the accepted host address and stays stable while `addr_valid` is high. `card_we` reflects the request direction.
- R9: `ack` lasts one cycle. A request raised while a card cycle is in progress is ignored, so exactly one acknowledge follows each accepted request.
- R10: Writing zero to a window's option register disables that window, so addresses it covered fall to the next matching window or miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_opt | input | 1 | 1 selects the option register, 0 the base register |
| cfg_idx | input | 3 | Window number to write |
| cfg_wdata | input | 32 | Configuration write data |
| req | input | 1 | Host access request, sampled while idle |
| req_we | input | 1 | 1 for a host write |
| req_addr | input | 32 | Host address |
| ack | output | 1 | One-cycle completion pulse |
| err | output | 1 | Completion with a miss or a protection violation |
| hit | output | 1 | Last accepted request matched a window |
| win_idx | output | 3 | Winning window number |
| space | output | 3 | Space code of the winning window |
| socket_b | output | 1 | Socket B selected |
| port16 | output | 1 | 16-bit card port |
| card_we | output | 1 | Direction of the card cycle |
| card_addr | output | 26 | Address presented to the card |
| addr_valid | output | 1 | Card address phase active |
| strobe | output | 1 | Card access strobe |

## Verification
A fault in the size decoding or in the priority selection appears at the ports as a wrong `hit` or `win_idx` on the first acknowledge after the request. The Gray-versus-binary distinction is tested with a size whose two readings cover different address ranges. A wrong phase counter shows up as a setup, strobe or hold run that is off by cycles. The bench measures each of these runs at the ports, so the error is seen within that same transaction. A state machine that accepted a second request while busy would produce an extra acknowledge or a changed `card_addr` in the middle of a cycle, both of which are counted directly.

// File: rtl/card_window_decoder.sv
module card_window_decoder #(
  parameter int NWIN = 8,
  parameter int AW   = 32,
  parameter int CAW  = 26,
  localparam int IW  = (NWIN > 1) ? $clog2(NWIN) : 1
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           cfg_we,
  input  logic           cfg_opt,
  input  logic [IW-1:0]  cfg_idx,
  input  logic [31:0]    cfg_wdata,
  input  logic           req,
  input  logic           req_we,
  input  logic [AW-1:0]  req_addr,
  output logic           ack,
  output logic           err,
  output logic           hit,
  output logic [IW-1:0]  win_idx,
  output logic [2:0]     space,
  output logic           socket_b,
  output logic           port16,
  output logic           card_we,
  output logic [CAW-1:0] card_addr,
  output logic           addr_valid,
  output logic           strobe
);
  localparam int B_VALID = 0;
  localparam int B_WP    = 1;
  localparam int B_SOCK  = 2;
  localparam int SP_LSB  = 3;
  localparam int B_P16   = 6;
  localparam int LN_LSB  = 7;
  localparam int SU_LSB  = 12;
  localparam int HO_LSB  = 16;
  localparam int SZ_LSB  = 27;

  typedef enum logic [2:0] {S_IDLE, S_SETUP, S_STRB, S_HOLD, S_DONE} st_t;

  logic [AW-1:0]   base_q [NWIN];
  logic [31:0]     opt_q  [NWIN];
  logic [NWIN-1:0] hv;
  logic [IW-1:0]   sel;
  logic            dec_hit;
  logic [31:0]     sel_opt;

  st_t        st, st_d, nxt;
  logic [4:0] cnt, cnt_d;
  logic [4:0] su_q, ln_q, ho_q, su_c, ln_c, ho_c;
  logic       err_q, wp_q;
  logic       bad;

  for (genvar i = 0; i < NWIN; i++) begin : g_win
    logic [4:0] lg;
    logic       unused_hi;
    always_comb begin
      lg[4] = opt_q[i][SZ_LSB+4];
      for (int k = 3; k >= 0; k--) lg[k] = lg[k+1] ^ opt_q[i][SZ_LSB+k];
    end
    assign hv[i] = opt_q[i][B_VALID] &&
                   (((req_addr ^ base_q[i]) & ({AW{1'b1}} << lg)) == '0);
    assign unused_hi = ^opt_q[i][SZ_LSB-1:HO_LSB+4];
  end

  always_comb begin
    sel = '0;
    for (int i = NWIN - 1; i >= 0; i--) if (hv[i]) sel = IW'(i);
  end
  assign dec_hit = |hv;
  assign sel_opt = opt_q[sel];
  assign bad     = !dec_hit || (req_we && sel_opt[B_WP]);

  function automatic st_t after(st_t cur, logic [4:0] s, logic [4:0] l, logic [4:0] h);
    if (cur == S_IDLE && s != 0) return S_SETUP;
    if ((cur == S_IDLE || cur == S_SETUP) && l != 0) return S_STRB;
    if (cur != S_HOLD && h != 0) return S_HOLD;
    return S_DONE;
  endfunction

  function automatic logic [4:0] len_of(st_t p, logic [4:0] s, logic [4:0] l, logic [4:0] h);
    case (p)
      S_SETUP: return s;
      S_STRB:  return l;
      S_HOLD:  return h;
      default: return 5'd0;
    endcase
  endfunction

  always_comb begin
    su_c = (st == S_IDLE) ? {1'b0, sel_opt[SU_LSB +: 4]} : su_q;
    ln_c = (st == S_IDLE) ? sel_opt[LN_LSB +: 5]         : ln_q;
    ho_c = (st == S_IDLE) ? {1'b0, sel_opt[HO_LSB +: 4]} : ho_q;
    nxt  = after(st, su_c, ln_c, ho_c);
    st_d  = st;
    cnt_d = cnt;
    case (st)
      S_IDLE:
        if (req) begin
          st_d  = bad ? S_DONE : nxt;
          cnt_d = bad ? 5'd0 : len_of(nxt, su_c, ln_c, ho_c);
        end
      S_SETUP, S_STRB, S_HOLD:
        if (cnt == 5'd1) begin
          st_d  = nxt;
          cnt_d = len_of(nxt, su_c, ln_c, ho_c);
        end else begin
          cnt_d = cnt - 5'd1;
        end
      default: st_d = S_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < NWIN; i++) begin
        base_q[i] <= '0;
        opt_q[i]  <= '0;
      end
      st <= S_IDLE;  cnt <= '0;
      su_q <= '0;  ln_q <= '0;  ho_q <= '0;
      err_q <= 1'b0;  wp_q <= 1'b0;  hit <= 1'b0;  win_idx <= '0;
      space <= '0;  socket_b <= 1'b0;  port16 <= 1'b0;
      card_we <= 1'b0;  card_addr <= '0;
    end else begin
      if (cfg_we) begin
        if (cfg_opt) opt_q[cfg_idx]  <= cfg_wdata;
        else         base_q[cfg_idx] <= cfg_wdata[AW-1:0];
      end
      st  <= st_d;
      cnt <= cnt_d;
      if (st == S_IDLE && req) begin
        err_q     <= bad;
        wp_q      <= sel_opt[B_WP];
        hit       <= dec_hit;
        win_idx   <= sel;
        space     <= sel_opt[SP_LSB +: 3];
        socket_b  <= sel_opt[B_SOCK];
        port16    <= sel_opt[B_P16];
        card_we   <= req_we;
        card_addr <= req_addr[CAW-1:0];
        su_q <= su_c;  ln_q <= ln_c;  ho_q <= ho_c;
      end
    end
  end

  assign ack        = (st == S_DONE);
  assign err        = ack & err_q;
  assign strobe     = (st == S_STRB);
  assign addr_valid = (st == S_SETUP) || (st == S_STRB) || (st == S_HOLD);

  assert_ack_single_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ack |=> !ack);
  assert_no_protected_strobe_R6: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> !(card_we && wp_q));
  assert_lowest_wins_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (st == S_IDLE && req && dec_hit) |-> (hv & ((NWIN'(1) << sel) - NWIN'(1))) == '0);
  assert_strobe_framed_R7: assert property (@(posedge clk) disable iff (!rst_n)
    strobe |-> (addr_valid && !ack && !err_q));
  assert_addr_stable_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (addr_valid && $past(addr_valid)) |-> $stable(card_addr));
endmodule

// File: tb/test_card_window_decoder.sv
module test_card_window_decoder;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cfg_we = 1'b0, cfg_opt = 1'b0;
  logic [2:0] cfg_idx = '0;
  logic [31:0] cfg_wdata = '0;
  logic req = 1'b0, req_we = 1'b0;
  logic [31:0] req_addr = '0;
  logic ack, err, hit, socket_b, port16, card_we, addr_valid, strobe;
  logic [2:0] win_idx, space;
  logic [25:0] card_addr;

  card_window_decoder i_card_window_decoder (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_opt(cfg_opt), .cfg_idx(cfg_idx),
    .cfg_wdata(cfg_wdata), .req(req), .req_we(req_we), .req_addr(req_addr),
    .ack(ack), .err(err), .hit(hit), .win_idx(win_idx), .space(space),
    .socket_b(socket_b), .port16(port16), .card_we(card_we), .card_addr(card_addr),
    .addr_valid(addr_valid), .strobe(strobe));

  always #4 clk = ~clk;

  int n_run = 0, n_fail = 0;
  int r_su, r_ns, r_ho;
  logic r_ack, r_err, r_hit, r_sock, r_p16, r_we;
  logic [2:0] r_idx, r_space;
  logic [25:0] r_caddr;

  task automatic chk(string rq, logic [31:0] act, logic [31:0] exp);
    n_run++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", rq, act, exp);
    end
  endtask

  function automatic logic [31:0] mk(int lg, int su, int ln, int ho, bit p16, int sp, bit sb, bit wp);
    logic [31:0] v = '0;
    v[31:27] = 5'(lg ^ (lg >> 1));
    v[19:16] = 4'(ho);  v[15:12] = 4'(su);  v[11:7] = 5'(ln);
    v[6] = p16;  v[5:3] = 3'(sp);  v[2] = sb;  v[1] = wp;  v[0] = 1'b1;
    return v;
  endfunction

  task automatic wr(bit opt, int idx, logic [31:0] d);
    @(negedge clk);
    cfg_we = 1'b1; cfg_opt = opt; cfg_idx = 3'(idx); cfg_wdata = d;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic access(logic [31:0] a, bit w);
    @(negedge clk);
    req = 1'b1; req_we = w; req_addr = a;
    @(negedge clk);
    req = 1'b0;
    r_su = 0; r_ns = 0; r_ho = 0; r_ack = 1'b0;
    for (int k = 0; k < 300; k++) begin
      if (ack) begin
        r_ack = 1'b1; r_err = err; r_hit = hit; r_idx = win_idx; r_space = space;
        r_sock = socket_b; r_p16 = port16; r_we = card_we; r_caddr = card_addr;
        break;
      end
      if (strobe) r_ns++;
      else if (addr_valid) begin
        if (r_ns == 0) r_su++; else r_ho++;
      end
      @(negedge clk);
    end
  endtask

  task automatic t_reset;
    chk("R1 ack idle", ack, 0);
    chk("R1 strobe idle", strobe, 0);
    chk("R1 addr_valid idle", addr_valid, 0);
    access(32'h0000_0000, 0);
    chk("R1 ack after miss", r_ack, 1);
    chk("R1 err no window", r_err, 1);
    chk("R4 hit low", r_hit, 0);
    chk("R4 no cycle", r_su + r_ns + r_ho, 0);
  endtask

  task automatic t_memory;
    wr(0, 0, 32'h0010_0000);
    wr(1, 0, mk(16, 6, 24, 8, 1, 0, 0, 0));
    access(32'h0010_1234, 0);
    chk("R3 hit 64K window", r_hit, 1);
    chk("R2 idx", r_idx, 0);
    chk("R2 space common", r_space, 0);
    chk("R2 port16", r_p16, 1);
    chk("R2 socket A", r_sock, 0);
    chk("R7 setup 6", r_su, 6);
    chk("R7 strobe 24", r_ns, 24);
    chk("R7 hold 8", r_ho, 8);
    chk("R8 card addr", r_caddr, 26'h010_1234);
    chk("R8 card_we read", r_we, 0);
    chk("R7 err low", r_err, 0);
  endtask

  task automatic t_io;
    wr(0, 3, 32'h0300_0300);
    wr(1, 3, mk(4, 4, 8, 2, 0, 3, 1, 0));
    access(32'h0300_030F, 1);
    chk("R3 io hit top byte", r_hit, 1);
    chk("R2 io idx", r_idx, 3);
    chk("R2 io space", r_space, 3);
    chk("R2 socket B", r_sock, 1);
    chk("R2 8-bit port", r_p16, 0);
    chk("R7 io setup", r_su, 4);
    chk("R7 io strobe", r_ns, 8);
    chk("R7 io hold", r_ho, 2);
    chk("R8 io card addr", r_caddr, 26'h300_030F);
    chk("R8 card_we write", r_we, 1);
    access(32'h0300_0310, 0);
    chk("R3 io just above", r_hit, 0);
    chk("R4 miss err", r_err, 1);
  endtask

  task automatic t_sizes;
    wr(0, 1, 32'h0000_0055);
    wr(1, 1, mk(0, 1, 1, 1, 0, 2, 0, 0));
    access(32'h0000_0055, 0);
    chk("R3 one byte hit", r_hit, 1);
    chk("R2 attribute space", r_space, 2);
    access(32'h0000_0054, 0);
    chk("R3 one byte neighbour miss", r_hit, 0);
    wr(0, 4, 32'h0000_0080);
    wr(1, 4, mk(3, 1, 1, 1, 0, 6, 0, 0));
    access(32'h0000_0087, 0);
    chk("R3 gray size 8 top", r_hit, 1);
    chk("R2 space 6", r_space, 6);
    access(32'h0000_0088, 0);
    chk("R3 gray size 8 above", r_hit, 0);
  endtask

  task automatic t_priority;
    wr(0, 2, 32'h0200_0000);
    wr(1, 2, mk(12, 1, 2, 1, 0, 4, 0, 0));
    wr(0, 5, 32'h0200_0000);
    wr(1, 5, mk(20, 1, 3, 1, 1, 5, 1, 0));
    access(32'h0200_0100, 0);
    chk("R5 lowest index", r_idx, 2);
    chk("R5 lowest space", r_space, 4);
    chk("R5 lowest strobe", r_ns, 2);
    wr(1, 2, 32'h0);
    access(32'h0200_0100, 0);
    chk("R10 falls to window 5", r_idx, 5);
    chk("R10 space of 5", r_space, 5);
    wr(1, 5, 32'h0);
    access(32'h0200_0100, 0);
    chk("R10 all cleared miss", r_hit, 0);
  endtask

  task automatic t_protect;
    wr(0, 6, 32'h0400_0000);
    wr(1, 6, mk(8, 2, 3, 2, 0, 0, 0, 1));
    access(32'h0400_0010, 1);
    chk("R6 wp write err", r_err, 1);
    chk("R6 wp write hit", r_hit, 1);
    chk("R6 wp write no strobe", r_ns, 0);
    chk("R6 wp write no addr phase", r_su + r_ho, 0);
    access(32'h0400_0010, 0);
    chk("R6 wp read ok", r_err, 0);
    chk("R6 wp read strobe", r_ns, 3);
  endtask

  task automatic t_zero;
    wr(0, 7, 32'h0500_0000);
    wr(1, 7, mk(8, 0, 1, 0, 0, 0, 0, 0));
    access(32'h0500_0001, 0);
    chk("R7 zero setup", r_su, 0);
    chk("R7 single strobe", r_ns, 1);
    chk("R7 zero hold", r_ho, 0);
  endtask

  task automatic t_busy;
    int acks = 0;
    logic [25:0] seen = '0;
    @(negedge clk);
    req = 1'b1; req_we = 1'b0; req_addr = 32'h0010_0040;
    @(negedge clk);
    req = 1'b0;
    repeat (3) @(negedge clk);
    req = 1'b1; req_addr = 32'h0300_0301;
    @(negedge clk);
    req = 1'b0;
    for (int k = 0; k < 80; k++) begin
      if (ack) acks++;
      if (strobe) seen = card_addr;
      @(negedge clk);
    end
    chk("R9 one ack", acks, 1);
    chk("R9 first address kept", seen, 26'h010_0040);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    t_reset();
    t_memory();
    t_io();
    t_sizes();
    t_priority();
    t_protect();
    t_zero();
    t_busy();
    $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule